// File: doc/BRIEF.md
# UART Interrupt Status and Line Controller

This block gathers the interrupt events of a serial port into one eleven-bit raw status register and lets software choose which of them may reach the processor. Event logic elsewhere in the port (receive FIFO, transmit path, line-error detection, modem-line change detection) delivers single-cycle set pulses. Software reaches the block through a small word-addressed register interface. Through it, software can read the raw status, read and write the enable mask, read the masked status, and clear raw bits by writing ones to a clear register.

Six registered interrupt outputs are derived from the masked status. One line is the OR of every masked bit. The other five each cover a fixed group of bits: receive, transmit, receive timeout, modem status and line errors. This lets a system route the whole port to one interrupt input, or route each class of event to its own input.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the raw status, the mask and all six interrupt outputs become zero.
- R2: A one on bit i of `evt_set` at a clock edge sets raw status bit i at that edge, and the bit stays set until it is cleared. The status layout is: bit 0 RI, bit 1 CTS, bit 2 DCD, bit 3 DSR, bit 4 receive, bit 5 transmit (pulsed once per byte loaded for transmission), bit 6 receive timeout, bit 7 framing, bit 8 parity, bit 9 break, bit 10 overrun. Reading address 0 returns the raw status.
- R3: A write to address 3 (clear) clears each raw bit where the write data holds a one and leaves the bits where it holds a zero.
- R4: When a set pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R5: Address 1 holds the mask. A write stores bits 10:0 of the write data, and a read returns the stored mask.
- R6: Reading address 2 returns the raw status AND the mask.
- R7: Output line 0 is high when any bit of the masked status is set.
- R8: Output line 1 follows masked bit 4 (receive), line 2 follows masked bit 5 (transmit), and line 3 follows masked bit 6 (receive timeout).
- R9: Output line 4 is the OR of masked bits 3:0 (modem status). Output line 5 is the OR of masked bits 10:7 (errors).
- R10: The outputs are registered. After each clock edge they reflect the raw status and the mask as they stood before that edge, so a change appears on the lines one cycle after it appears in the registers.
- R11: Writes to address 0 and address 2 change no state. Reading address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_set | input | 11 | Single-cycle set pulses, one per status bit |
| bus_wr | input | 1 | Write strobe for the register interface |
| bus_addr | input | 2 | Register word address (0 raw, 1 mask, 2 masked, 3 clear) |
| bus_wdata | input | 11 | Write data |
| bus_rdata | output | 11 | Read data for `bus_addr`, combinational from register state |
| irq_lines | output | 6 | Registered interrupt outputs: 0 combined, 1 rx, 2 tx, 3 timeout, 4 modem, 5 error |

## Verification
The assertions assume that `evt_set`, `bus_wr`, `bus_addr` and `bus_wdata` are stable and known at every rising edge after reset. They also assume that a write strobe lasts exactly the cycle in which it is sampled. The bench drives all inputs on the falling edge and returns the strobes and pulses to zero after each step, so every sampled edge sees one settled value. Random steps draw arbitrary set vectors, addresses and data, including simultaneous set-and-clear on shared bits. This keeps every address and every overlap pattern within those assumptions.

// File: rtl/uart_irq_pkg.sv
// Shared constants, register selector type and line grouping for the UART
// interrupt controller. Assumes the fixed eleven-bit status layout.
package uart_irq_pkg;

    localparam int STAT_W    = 11;
    localparam int NUM_LINES = 6;
    localparam int ADDR_W    = 2;

    // Status bit positions
    localparam int BIT_RI   = 0;
    localparam int BIT_CTS  = 1;
    localparam int BIT_DCD  = 2;
    localparam int BIT_DSR  = 3;
    localparam int BIT_RX   = 4;
    localparam int BIT_TX   = 5;
    localparam int BIT_RTO  = 6;
    localparam int BIT_FRM  = 7;
    localparam int BIT_PAR  = 8;
    localparam int BIT_BRK  = 9;
    localparam int BIT_OVR  = 10;

    localparam logic [STAT_W-1:0] GRP_MODEM = (STAT_W'(1) << BIT_RI)  | (STAT_W'(1) << BIT_CTS)
                                            | (STAT_W'(1) << BIT_DCD) | (STAT_W'(1) << BIT_DSR);
    localparam logic [STAT_W-1:0] GRP_ERR   = (STAT_W'(1) << BIT_FRM) | (STAT_W'(1) << BIT_PAR)
                                            | (STAT_W'(1) << BIT_BRK) | (STAT_W'(1) << BIT_OVR);
    localparam logic [STAT_W-1:0] GRP_ALL   = {STAT_W{1'b1}};

    typedef enum logic [ADDR_W-1:0] {
        SEL_RAW    = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_MASKED = 2'd2,
        SEL_CLEAR  = 2'd3
    } reg_sel_e;

    // Which status bits drive output line idx
    function automatic logic [STAT_W-1:0] line_group(input int idx);
        logic [STAT_W-1:0] g;
        case (idx)
            0:       g = GRP_ALL;
            1:       g = STAT_W'(1) << BIT_RX;
            2:       g = STAT_W'(1) << BIT_TX;
            3:       g = STAT_W'(1) << BIT_RTO;
            4:       g = GRP_MODEM;
            5:       g = GRP_ERR;
            default: g = '0;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/irq_reg_access.sv
// Register interface decode and read multiplexer.
// Turns a write strobe and address into a mask write enable and a clear
// vector, and selects read data from the state. Assumes single-cycle strobes.
module irq_reg_access
    import uart_irq_pkg::*;
#(
    parameter int W  = STAT_W,
    parameter int AW = ADDR_W
) (
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    input  logic [W-1:0]  raw_q,
    input  logic [W-1:0]  mask_q,
    output logic          mask_we,
    output logic [W-1:0]  mask_wdata,
    output logic [W-1:0]  clr_vec,
    output logic [W-1:0]  bus_rdata
);

    reg_sel_e sel;

    assign sel        = reg_sel_e'(bus_addr);
    assign mask_wdata = bus_wdata;

    // Write decode: only mask and clear registers accept writes
    always_comb begin
        mask_we = 1'b0;
        clr_vec = '0;
        if (bus_wr) begin
            case (sel)
                SEL_MASK:  mask_we = 1'b1;
                SEL_CLEAR: clr_vec = bus_wdata;
                default:   ;
            endcase
        end
    end

    // Read multiplexer: clear register reads as zero
    always_comb begin
        case (sel)
            SEL_RAW:    bus_rdata = raw_q;
            SEL_MASK:   bus_rdata = mask_q;
            SEL_MASKED: bus_rdata = raw_q & mask_q;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_raw_status.sv
// Raw interrupt status register. Each bit is set by its event pulse and
// cleared by a one in the clear vector; a set in the same cycle wins.
// Assumes event pulses last one cycle (longer pulses simply re-set the bit).
module irq_raw_status #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_set,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] raw_q
);

    // Per-bit sticky status with set-over-clear priority
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr_vec) | evt_set;
    end

endmodule

// File: rtl/irq_mask_reg.sv
// Interrupt enable mask register, written as a whole word.
// Assumes the write enable is already qualified by address decode.
module irq_mask_reg #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    output logic [W-1:0] mask_q
);

    // Hold mask, load on write
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

endmodule

// File: rtl/irq_line_combine.sv
// Builds the registered interrupt outputs from the masked status.
// One line per group in the package table; assumes NL <= entries defined.
module irq_line_combine
    import uart_irq_pkg::*;
#(
    parameter int W  = STAT_W,
    parameter int NL = NUM_LINES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  masked,
    output logic [NL-1:0] irq_lines
);

    for (genvar li = 0; li < NL; li++) begin : g_line
        localparam logic [W-1:0] GRP = W'(line_group(li));
        // Register OR-reduction of this line's group
        always_ff @(posedge clk) begin
            if (!rst_n) irq_lines[li] <= 1'b0;
            else        irq_lines[li] <= |(masked & GRP);
        end
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
// UART interrupt controller top: raw status, mask, masked view, clear
// register and six registered interrupt outputs.
// Assumes event pulses come from logic in the same clock domain.
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int W  = STAT_W,
    parameter int AW = ADDR_W,
    parameter int NL = NUM_LINES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  evt_set,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    output logic [NL-1:0] irq_lines
);

    logic [W-1:0] raw_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] clr_vec;
    logic [W-1:0] mask_wdata;
    logic         mask_we;
    logic [W-1:0] masked;

    assign masked = raw_q & mask_q;

    irq_reg_access #(.W(W), .AW(AW)) u_access (
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .raw_q      (raw_q),
        .mask_q     (mask_q),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .clr_vec    (clr_vec),
        .bus_rdata  (bus_rdata)
    );

    irq_raw_status #(.W(W)) u_raw (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_set (evt_set),
        .clr_vec (clr_vec),
        .raw_q   (raw_q)
    );

    irq_mask_reg #(.W(W)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .mask_q     (mask_q)
    );

    irq_line_combine #(.W(W), .NL(NL)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .masked    (masked),
        .irq_lines (irq_lines)
    );

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
// Property checker for uart_irq_ctrl, bound to every instance.
// Assumes the default layout (11 status bits, 6 lines, 2-bit address).
module uart_irq_ctrl_chk
    import uart_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [STAT_W-1:0] evt_set,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [STAT_W-1:0] bus_wdata,
    input logic [STAT_W-1:0] bus_rdata,
    input logic [NUM_LINES-1:0] irq_lines,
    input logic [STAT_W-1:0] raw_q,
    input logic [STAT_W-1:0] mask_q
);

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_lines == '0 && raw_q == '0 && mask_q == '0));

    p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((raw_q & $past(evt_set)) == $past(evt_set)));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_CLEAR && evt_set == '0) |=> ((raw_q & $past(bus_wdata)) == '0));

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_CLEAR && (evt_set & bus_wdata) != '0)
        |=> ((raw_q & $past(evt_set & bus_wdata)) == $past(evt_set & bus_wdata)));

    p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SEL_MASK) |=> (mask_q == $past(bus_wdata)));

    p_masked_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == SEL_MASKED) |-> (bus_rdata == (raw_q & mask_q)));

    p_combined_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_lines[0] == |$past(raw_q & mask_q)));

    p_error_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_lines[5] == |($past(raw_q & mask_q) & GRP_ERR)));

    p_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(raw_q & mask_q)) |=> $stable(irq_lines));

    p_no_effect_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == SEL_RAW || bus_addr == SEL_MASKED) && evt_set == '0)
        |=> ($stable(raw_q) && $stable(mask_q)));

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_set   (evt_set),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_lines (irq_lines),
    .raw_q     (raw_q),
    .mask_q    (mask_q)
);

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] evt_set = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [10:0] bus_wdata = '0;
    logic [10:0] bus_rdata;
    logic [5:0]  irq_lines;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [10:0] raw_m = '0;
    logic [10:0] mask_m = '0;

    always #5 clk = ~clk;

    uart_irq_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_set   (evt_set),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_lines (irq_lines)
    );

    function automatic logic [5:0] exp_lines(input logic [10:0] m);
        logic [5:0] l;
        l[0] = |m;
        l[1] = m[4];
        l[2] = m[5];
        l[3] = m[6];
        l[4] = |m[3:0];
        l[5] = |m[10:7];
        return l;
    endfunction

    function automatic logic [10:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return raw_m;
            2'd1:    return mask_m;
            2'd2:    return raw_m & mask_m;
            default: return 11'h0;
        endcase
    endfunction

    function automatic string read_tag(input logic [1:0] a);
        case (a)
            2'd0:    return "R2";
            2'd1:    return "R5";
            2'd2:    return "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_lines(input logic [5:0] exp);
        check("R7 combined", 11'(irq_lines[0]), 11'(exp[0]));
        check("R8 rx/tx/timeout", 11'(irq_lines[3:1]), 11'(exp[3:1]));
        check("R9 modem/error", 11'(irq_lines[5:4]), 11'(exp[5:4]));
    endtask

    // One clock step: drive, check read, model update at edge, check lines
    task automatic step(input logic [10:0] ev, input logic wr,
                        input logic [1:0] a, input logic [10:0] d);
        logic [5:0] el;
        evt_set = ev; bus_wr = wr; bus_addr = a; bus_wdata = d;
        #1;
        check(read_tag(a), bus_rdata, exp_read(a));
        @(posedge clk);
        el = exp_lines(raw_m & mask_m);
        if (wr && a == 2'd1) mask_m = d;
        if (wr && a == 2'd3) raw_m = raw_m & ~d;
        raw_m = raw_m | ev;
        @(negedge clk);
        evt_set = '0; bus_wr = 1'b0;
        check_lines(el);
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp_read(a));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 lines", 11'(irq_lines), 11'h0);
        rd(2'd0, "R1 raw");
        rd(2'd1, "R1 mask");
        rst_n = 1'b1;
        @(negedge clk);

        // R10: set with mask on; lines lag the status by one cycle
        step(11'h000, 1'b1, 2'd1, 11'h7FF);
        evt_set = 11'h020; bus_addr = 2'd0;
        @(posedge clk);
        raw_m = raw_m | 11'h020;
        @(negedge clk);
        evt_set = '0;
        check("R10 lines still low", 11'(irq_lines), 11'h0);
        rd(2'd0, "R2 tx bit set");
        step(11'h000, 1'b0, 2'd0, 11'h0);
        check("R8 tx line", 11'(irq_lines[2]), 11'h1);

        // R3: partial clear leaves zeros alone
        step(11'h7FF, 1'b0, 2'd0, 11'h0);
        step(11'h000, 1'b1, 2'd3, 11'h0F0);
        rd(2'd0, "R3 partial clear");
        check("R3 value", bus_rdata, 11'h70F);

        // R4: set beats clear on same bit
        step(11'h010, 1'b1, 2'd3, 11'h7FF);
        rd(2'd0, "R4 set wins");
        check("R4 value", bus_rdata, 11'h010);

        // R11: writes to raw and masked addresses are ignored
        step(11'h000, 1'b1, 2'd0, 11'h7FF);
        step(11'h000, 1'b1, 2'd2, 11'h000);
        rd(2'd0, "R11 raw untouched");
        rd(2'd1, "R11 mask untouched");
        rd(2'd3, "R11 clear reads zero");

        // R9: error group only, modem group only
        step(11'h000, 1'b1, 2'd3, 11'h7FF);
        step(11'h000, 1'b1, 2'd1, 11'h780);
        step(11'h081, 1'b0, 2'd0, 11'h0);
        step(11'h000, 1'b0, 2'd2, 11'h0);
        check("R9 error line", 11'(irq_lines[5]), 11'h1);
        check("R9 modem line masked", 11'(irq_lines[4]), 11'h0);

        // Random mix
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            logic [10:0] ev;
            logic [10:0] d;
            ev = ($urandom % 4 == 0) ? 11'($urandom) : 11'h0;
            d  = 11'($urandom);
            step(ev, 1'($urandom % 2), 2'($urandom), d);
        end

        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        raw_m = '0; mask_m = '0;
        check("R1 lines after reset", 11'(irq_lines), 11'h0);
        rd(2'd0, "R1 raw after reset");
        rd(2'd1, "R1 mask after reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule